// File: doc/BRIEF.md
# Instruction/Data Micro-TLB Pair

This block is the first translation stage in front of a shared second-level TLB. It holds two small, fully associative page caches that hardware fills on its own: a 4-entry cache for instruction fetch and an 8-entry cache for data accesses. Each side accepts one virtual address at a time. A hit returns the physical address quickly. A miss sends the virtual page number to the second level over a single request/response port, writes the answer into a victim entry and then returns the physical address.

Each entry carries an age counter. The victim on a refill is chosen from these counters. When both sides miss in the same cycle, the data side uses the second-level port first. If the second level has no translation, both caches are emptied, the requesting side raises a fault, and translation is locked until the operating system reports that its reload is finished. A write to any second-level entry also empties both caches.

Top module: `xl1_pair`

## Requirements
- R1: The instruction cache holds I_ENTRIES (default 4) and the data cache holds D_ENTRIES (default 8) translations. Each is fully associative, so it keeps that many distinct page numbers resident at once.
- R2: A request is accepted on a rising edge where the side's ready is high. On a hit, done pulses for one cycle after the second rising edge from acceptance (latency 2). Its physical address is the cached physical page number concatenated with the low OFF_W (default 12) address bits.
- R3: On a hit, the hit entry's age becomes zero and every other entry's age rises by one.
- R4: Ages saturate at twice the entry count minus one (7 for the instruction side, 15 for the data side).
- R5: The refill victim is the lowest-indexed invalid entry if one exists. Otherwise it is the entry with the highest age, with ties going to the lowest index. A refilled entry starts at age zero, and the other ages do not change.
- R6: On a miss, l2_req rises with l2_vpn and holds both until a cycle with l2_rsp_valid high. With a second level that answers in the cycle after the request, a data miss completes with latency 5 and physical page l2_rsp_ppn.
- R7: When both sides miss in the same cycle, the data side is served first (data latency 5, instruction latency 7). An instruction miss alone has latency 5.
- R8: A response with l2_rsp_hit low gives a one-cycle fault pulse on the requesting side (latency 3) and no done pulse. It invalidates both caches, sets locked, holds both ready outputs low and issues no l2_req until os_reload_done pulses.
- R9: A pulse on l2_wr invalidates every entry of both caches.
- R10: After reset both caches are empty, both ready outputs are high, and locked, l2_req, done and fault are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| i_req | input | 1 | Instruction translation request |
| i_va | input | VA_W | Instruction virtual address |
| i_ready | output | 1 | Instruction side can take a request |
| i_done | output | 1 | Instruction translation complete |
| i_pa | output | PA_W | Instruction physical address, valid with i_done |
| i_fault | output | 1 | Instruction second-level miss pulse |
| d_req | input | 1 | Data translation request |
| d_va | input | VA_W | Data virtual address |
| d_ready | output | 1 | Data side can take a request |
| d_done | output | 1 | Data translation complete |
| d_pa | output | PA_W | Data physical address, valid with d_done |
| d_fault | output | 1 | Data second-level miss pulse |
| l2_req | output | 1 | Second-level lookup request |
| l2_vpn | output | VA_W-OFF_W | Page number looked up |
| l2_rsp_valid | input | 1 | Second-level response present |
| l2_rsp_hit | input | 1 | Second level holds the page |
| l2_rsp_ppn | input | PA_W-OFF_W | Physical page returned |
| l2_wr | input | 1 | A second-level entry was written |
| os_reload_done | input | 1 | Operating system finished its reload |
| locked | output | 1 | Translation locked after a second-level miss |

## Verification
A wrong age counter or a wrong victim does not show up when the bad entry is evicted. It shows up later, when a page that should still be resident is requested again and takes the 5-cycle miss path instead of completing in 2 cycles. The bench therefore runs a reference model of both caches and predicts every latency, so that such an eviction is caught on the first re-reference. Lost invalidation shows as a 2-cycle hit right after l2_wr or a reload. Wrong arbitration shows as swapped 5/7 latencies on a simultaneous miss.

// File: rtl/xl1_pkg.sv
package xl1_pkg;
   typedef enum logic {
      XL1_INS = 1'b0,
      XL1_DAT = 1'b1
   } xl1_side_e;
endpackage

// File: rtl/xl1_cache.sv
// Fully associative page cache with saturating per-entry age counters.
module xl1_cache #(
   parameter int ENTRIES = 4,
   parameter int VPN_W   = 20,
   parameter int PPN_W   = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             look_en,
   input  logic [VPN_W-1:0] look_vpn,
   output logic             hit,
   output logic [PPN_W-1:0] hit_ppn,
   input  logic             fill_en,
   input  logic [VPN_W-1:0] fill_vpn,
   input  logic [PPN_W-1:0] fill_ppn,
   input  logic             flush
);
   localparam int CEIL  = 2 * ENTRIES - 1;
   localparam int CNT_W = $clog2(2 * ENTRIES);
   localparam int IDX_W = $clog2(ENTRIES);

   logic [ENTRIES-1:0] vld;
   logic [ENTRIES-1:0] match;
   logic [VPN_W-1:0]   tag  [ENTRIES];
   logic [PPN_W-1:0]   phys [ENTRIES];
   logic [CNT_W-1:0]   age  [ENTRIES];
   logic [IDX_W-1:0]   hit_idx;
   logic [IDX_W-1:0]   vic_idx;
   logic [CNT_W-1:0]   best_age;
   logic               free_seen;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign match[g] = vld[g] && (tag[g] == look_vpn);
   end

   always_comb begin
      hit_idx = '0;
      for (int e = ENTRIES - 1; e >= 0; e--) begin
         if (match[e]) hit_idx = IDX_W'(e);
      end
   end
   assign hit     = |match;
   assign hit_ppn = phys[hit_idx];

   // Victim: lowest free slot, else oldest with ties to the lowest index.
   always_comb begin
      free_seen = 1'b0;
      vic_idx   = '0;
      best_age  = age[0];
      for (int e = 0; e < ENTRIES; e++) begin
         if (!vld[e] && !free_seen) begin
            free_seen = 1'b1;
            vic_idx   = IDX_W'(e);
         end
      end
      if (!free_seen) begin
         for (int e = 1; e < ENTRIES; e++) begin
            if (age[e] > best_age) begin
               best_age = age[e];
               vic_idx  = IDX_W'(e);
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld <= '0;
         for (int e = 0; e < ENTRIES; e++) age[e] <= '0;
      end else if (flush) begin
         vld <= '0;
         for (int e = 0; e < ENTRIES; e++) age[e] <= '0;
      end else if (fill_en) begin
         vld[vic_idx] <= 1'b1;
         age[vic_idx] <= '0;
      end else if (look_en && hit) begin
         for (int e = 0; e < ENTRIES; e++) begin
            if (match[e])                      age[e] <= '0;
            else if (age[e] != CNT_W'(CEIL))   age[e] <= age[e] + 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (fill_en && !flush) begin
         tag[vic_idx]  <= fill_vpn;
         phys[vic_idx] <= fill_ppn;
      end
   end
endmodule

// File: rtl/xl1_side.sv
// One translation side: lookup stage, miss wait, refill and finish.
module xl1_side #(
   parameter int ENTRIES = 4,
   parameter int VA_W    = 32,
   parameter int OFF_W   = 12,
   parameter int PPN_W   = 20
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req,
   input  logic [VA_W-1:0]        va,
   output logic                   ready,
   output logic                   done,
   output logic [PPN_W+OFF_W-1:0] pa,
   output logic                   fault,
   output logic                   l2_want,
   output logic [VA_W-OFF_W-1:0]  want_vpn,
   input  logic                   rsp_fire,
   input  logic                   rsp_hit,
   input  logic [PPN_W-1:0]       rsp_ppn,
   input  logic                   flush,
   input  logic                   locked
);
   localparam int VPN_W = VA_W - OFF_W;

   logic             s1_vld, wait_l2, fill_vld, fin_vld;
   logic [VA_W-1:0]  addr;
   logic [PPN_W-1:0] fill_ppn;
   logic             hit;
   logic [PPN_W-1:0] hit_ppn;

   xl1_cache #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_cache (
      .clk      (clk),
      .rst_n    (rst_n),
      .look_en  (s1_vld),
      .look_vpn (addr[VA_W-1:OFF_W]),
      .hit      (hit),
      .hit_ppn  (hit_ppn),
      .fill_en  (fill_vld),
      .fill_vpn (addr[VA_W-1:OFF_W]),
      .fill_ppn (fill_ppn),
      .flush    (flush)
   );

   assign ready    = !(s1_vld || wait_l2 || fill_vld || fin_vld) && !locked;
   assign l2_want  = (s1_vld && !hit) || wait_l2;
   assign want_vpn = addr[VA_W-1:OFF_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_vld   <= 1'b0;
         wait_l2  <= 1'b0;
         fill_vld <= 1'b0;
         fin_vld  <= 1'b0;
         done     <= 1'b0;
         fault    <= 1'b0;
         addr     <= '0;
         fill_ppn <= '0;
         pa       <= '0;
      end else begin
         done  <= 1'b0;
         fault <= 1'b0;
         if (req && ready) begin
            s1_vld <= 1'b1;
            addr   <= va;
         end
         if (s1_vld) begin
            s1_vld <= 1'b0;
            if (hit) begin
               done <= 1'b1;
               pa   <= {hit_ppn, addr[OFF_W-1:0]};
            end else begin
               wait_l2 <= 1'b1;
            end
         end
         if (rsp_fire) begin
            wait_l2 <= 1'b0;
            if (rsp_hit) begin
               fill_vld <= 1'b1;
               fill_ppn <= rsp_ppn;
            end else begin
               fault <= 1'b1;
            end
         end
         if (fill_vld) begin
            fill_vld <= 1'b0;
            fin_vld  <= 1'b1;
         end
         if (fin_vld) begin
            fin_vld <= 1'b0;
            done    <= 1'b1;
            pa      <= {fill_ppn, addr[OFF_W-1:0]};
         end
      end
   end
endmodule

// File: rtl/xl1_l2_arb.sv
// Shared second-level port: data side wins when both wait.
module xl1_l2_arb
   import xl1_pkg::*;
#(
   parameter int VPN_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             locked,
   input  logic             d_want,
   input  logic [VPN_W-1:0] d_vpn,
   input  logic             i_want,
   input  logic [VPN_W-1:0] i_vpn,
   output logic             l2_req,
   output xl1_side_e        l2_sel,
   output logic [VPN_W-1:0] l2_vpn,
   input  logic             rsp_valid,
   output logic             d_fire,
   output logic             i_fire
);
   logic fire;
   assign fire   = l2_req && rsp_valid;
   assign d_fire = fire && (l2_sel == XL1_DAT);
   assign i_fire = fire && (l2_sel == XL1_INS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         l2_req <= 1'b0;
         l2_sel <= XL1_DAT;
         l2_vpn <= '0;
      end else if (fire) begin
         l2_req <= 1'b0;
      end else if (!l2_req && !locked) begin
         if (d_want) begin
            l2_req <= 1'b1;
            l2_sel <= XL1_DAT;
            l2_vpn <= d_vpn;
         end else if (i_want) begin
            l2_req <= 1'b1;
            l2_sel <= XL1_INS;
            l2_vpn <= i_vpn;
         end
      end
   end
endmodule

// File: rtl/xl1_pair.sv
module xl1_pair
   import xl1_pkg::*;
#(
   parameter int VA_W      = 32,
   parameter int PA_W      = 32,
   parameter int OFF_W     = 12,
   parameter int I_ENTRIES = 4,
   parameter int D_ENTRIES = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  i_req,
   input  logic [VA_W-1:0]       i_va,
   output logic                  i_ready,
   output logic                  i_done,
   output logic [PA_W-1:0]       i_pa,
   output logic                  i_fault,
   input  logic                  d_req,
   input  logic [VA_W-1:0]       d_va,
   output logic                  d_ready,
   output logic                  d_done,
   output logic [PA_W-1:0]       d_pa,
   output logic                  d_fault,
   output logic                  l2_req,
   output logic [VA_W-OFF_W-1:0] l2_vpn,
   input  logic                  l2_rsp_valid,
   input  logic                  l2_rsp_hit,
   input  logic [PA_W-OFF_W-1:0] l2_rsp_ppn,
   input  logic                  l2_wr,
   input  logic                  os_reload_done,
   output logic                  locked
);
   localparam int VPN_W = VA_W - OFF_W;
   localparam int PPN_W = PA_W - OFF_W;

   if (OFF_W < 1 || OFF_W >= VA_W || OFF_W >= PA_W) begin : g_bad_off
      $error("xl1_pair: OFF_W must be below both address widths");
   end
   if (I_ENTRIES < 2 || D_ENTRIES < 2) begin : g_bad_depth
      $error("xl1_pair: each cache needs at least two entries");
   end

   logic             i_want, d_want, i_fire, d_fire, flush;
   logic [VPN_W-1:0] i_wvpn, d_wvpn;
   xl1_side_e        arb_sel;

   assign flush = ((i_fire || d_fire) && !l2_rsp_hit) || l2_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  locked <= 1'b0;
      else if ((i_fire || d_fire) && !l2_rsp_hit)  locked <= 1'b1;
      else if (os_reload_done)                     locked <= 1'b0;
   end

   xl1_side #(.ENTRIES(I_ENTRIES), .VA_W(VA_W), .OFF_W(OFF_W), .PPN_W(PPN_W)) u_ins (
      .clk(clk), .rst_n(rst_n), .req(i_req), .va(i_va), .ready(i_ready),
      .done(i_done), .pa(i_pa), .fault(i_fault), .l2_want(i_want), .want_vpn(i_wvpn),
      .rsp_fire(i_fire), .rsp_hit(l2_rsp_hit), .rsp_ppn(l2_rsp_ppn),
      .flush(flush), .locked(locked)
   );

   xl1_side #(.ENTRIES(D_ENTRIES), .VA_W(VA_W), .OFF_W(OFF_W), .PPN_W(PPN_W)) u_dat (
      .clk(clk), .rst_n(rst_n), .req(d_req), .va(d_va), .ready(d_ready),
      .done(d_done), .pa(d_pa), .fault(d_fault), .l2_want(d_want), .want_vpn(d_wvpn),
      .rsp_fire(d_fire), .rsp_hit(l2_rsp_hit), .rsp_ppn(l2_rsp_ppn),
      .flush(flush), .locked(locked)
   );

   xl1_l2_arb #(.VPN_W(VPN_W)) u_arb (
      .clk(clk), .rst_n(rst_n), .locked(locked),
      .d_want(d_want), .d_vpn(d_wvpn), .i_want(i_want), .i_vpn(i_wvpn),
      .l2_req(l2_req), .l2_sel(arb_sel), .l2_vpn(l2_vpn),
      .rsp_valid(l2_rsp_valid), .d_fire(d_fire), .i_fire(i_fire)
   );
endmodule

// File: rtl/xl1_pair_chk.sv
module xl1_pair_chk #(
   parameter int VPN_W = 20
) (
   input logic             clk,
   input logic             rst_n,
   input logic             l2_req,
   input logic             l2_rsp_valid,
   input logic [VPN_W-1:0] l2_vpn,
   input logic             l2_sel,
   input logic             locked,
   input logic             i_ready,
   input logic             d_ready,
   input logic             i_done,
   input logic             d_done,
   input logic             i_fault,
   input logic             d_fault,
   input logic             i_want,
   input logic             d_want
);
   assert_req_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
      l2_req && !l2_rsp_valid |=> l2_req && $stable(l2_vpn));

   assert_data_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !l2_req && !locked && d_want && i_want |=> l2_req && l2_sel);

   assert_lock_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      locked && !l2_req |=> !l2_req);

   assert_lock_closed_R8: assert property (@(posedge clk) disable iff (!rst_n)
      locked |-> !i_ready && !d_ready);

   assert_fault_locks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (i_fault || d_fault) |-> locked);

   assert_fault_no_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(i_done && i_fault) && !(d_done && d_fault));

   assert_d_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      d_done |=> !d_done);

   assert_i_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      i_done |=> !i_done);
endmodule

bind xl1_pair xl1_pair_chk #(.VPN_W(VA_W - OFF_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .l2_req(l2_req), .l2_rsp_valid(l2_rsp_valid),
   .l2_vpn(l2_vpn), .l2_sel(arb_sel), .locked(locked), .i_ready(i_ready),
   .d_ready(d_ready), .i_done(i_done), .d_done(d_done), .i_fault(i_fault),
   .d_fault(d_fault), .i_want(i_want), .d_want(d_want)
);

// File: tb/xl1_pair_tb_top.sv
module xl1_pair_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        i_req = 1'b0, d_req = 1'b0;
   logic [31:0] i_va = '0, d_va = '0;
   logic        i_ready, i_done, i_fault, d_ready, d_done, d_fault;
   logic [31:0] i_pa, d_pa;
   logic        l2_req;
   logic [19:0] l2_vpn;
   logic        l2_rsp_valid = 1'b0, l2_rsp_hit = 1'b0;
   logic [19:0] l2_rsp_ppn = '0;
   logic        l2_wr = 1'b0, os_reload_done = 1'b0;
   logic        locked;

   int n_checks = 0;
   int n_fail   = 0;
   int cyc      = 0;

   typedef struct {
      logic [31:0] pa;
      int          lat;
      bit          flt;
      int          t0;
      string       tag;
   } exp_t;
   exp_t qi[$];
   exp_t qd[$];

   // reference model of both caches (index 0 instruction, 1 data)
   bit          mv   [2][8];
   logic [19:0] mtag [2][8];
   int          mcnt [2][8];

   xl1_pair dut_i (
      .clk(clk), .rst_n(rst_n),
      .i_req(i_req), .i_va(i_va), .i_ready(i_ready), .i_done(i_done), .i_pa(i_pa), .i_fault(i_fault),
      .d_req(d_req), .d_va(d_va), .d_ready(d_ready), .d_done(d_done), .d_pa(d_pa), .d_fault(d_fault),
      .l2_req(l2_req), .l2_vpn(l2_vpn), .l2_rsp_valid(l2_rsp_valid), .l2_rsp_hit(l2_rsp_hit),
      .l2_rsp_ppn(l2_rsp_ppn), .l2_wr(l2_wr), .os_reload_done(os_reload_done), .locked(locked)
   );

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [19:0] l2map(input logic [19:0] v);
      return v ^ 20'h5A3C1;
   endfunction
   function automatic bit absent(input logic [19:0] v);
      return v[19:16] == 4'hF;
   endfunction

   // second level: answers in the cycle after a request
   always @(negedge clk) begin
      l2_rsp_valid = l2_req;
      l2_rsp_hit   = !absent(l2_vpn);
      l2_rsp_ppn   = l2map(l2_vpn);
   end

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   function automatic void mflush();
      for (int s = 0; s < 2; s++)
         for (int e = 0; e < 8; e++) begin mv[s][e] = 0; mcnt[s][e] = 0; end
   endfunction

   // 0 = hit, 1 = miss filled, 2 = second-level miss
   function automatic int model(input int s, input logic [19:0] vpn);
      int n = (s != 0) ? 8 : 4;
      int ceil = 2 * n - 1;
      int h = -1;
      int vic = -1;
      for (int e = 0; e < n; e++) if (mv[s][e] && mtag[s][e] == vpn && h < 0) h = e;
      if (h >= 0) begin
         for (int e = 0; e < n; e++)
            if (e == h) mcnt[s][e] = 0;
            else if (mcnt[s][e] < ceil) mcnt[s][e]++;
         return 0;
      end
      if (absent(vpn)) begin mflush(); return 2; end
      for (int e = 0; e < n; e++) if (!mv[s][e] && vic < 0) vic = e;
      if (vic < 0) begin
         vic = 0;
         for (int e = 1; e < n; e++) if (mcnt[s][e] > mcnt[s][vic]) vic = e;
      end
      mv[s][vic] = 1; mtag[s][vic] = vpn; mcnt[s][vic] = 0;
      return 1;
   endfunction

   task automatic issue(input int s, input logic [19:0] vpn, input logic [11:0] off,
                        input bit behind, input string tag);
      exp_t e;
      int r;
      @(negedge clk);
      while (!((s != 0) ? d_ready : i_ready)) @(negedge clk);
      r = model(s, vpn);
      e.pa  = {l2map(vpn), off};
      e.flt = (r == 2);
      e.lat = (r == 0) ? 2 : (r == 2) ? 3 : (behind ? 7 : 5);
      e.t0  = cyc;
      e.tag = tag;
      if (s != 0) begin qd.push_back(e); d_req = 1; d_va = {vpn, off}; end
      else        begin qi.push_back(e); i_req = 1; i_va = {vpn, off}; end
      @(negedge clk);
      if (s != 0) d_req = 0; else i_req = 0;
   endtask

   task automatic settle();
      @(negedge clk);
      while (qi.size() != 0 || qd.size() != 0) @(negedge clk);
   endtask

   task automatic run1(input int s, input logic [19:0] vpn, input logic [11:0] off, input string tag);
      issue(s, vpn, off, 0, tag);
      settle();
   endtask

   task automatic pop_cmp(input int s, input bit got_flt, input logic [31:0] pa);
      exp_t e;
      if ((s != 0 ? qd.size() : qi.size()) == 0) begin
         chk(0, "R2", "unexpected completion", pa, 0);
         return;
      end
      e = (s != 0) ? qd.pop_front() : qi.pop_front();
      chk(got_flt == e.flt, e.tag, "fault flag", got_flt, e.flt);
      chk(cyc - e.t0 == e.lat, e.tag, "latency", cyc - e.t0, e.lat);
      if (!e.flt) chk(pa == e.pa, e.tag, "physical address", pa, e.pa);
   endtask

   // monitor: compare completions against the scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (d_done || d_fault) pop_cmp(1, d_fault, d_pa);
         if (i_done || i_fault) pop_cmp(0, i_fault, i_pa);
      end
   end

   task automatic main();
      logic [19:0] a;
      int lcg = 7;
      mflush();
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R10 reset state
      chk(i_ready && d_ready, "R10", "ready after reset", {i_ready, d_ready}, 2'b11);
      chk(!locked && !l2_req, "R10", "locked/l2_req after reset", {locked, l2_req}, 0);
      chk(!i_done && !d_done && !i_fault && !d_fault, "R10", "done/fault after reset", 0, 0);
      run1(1, 20'h00100, 12'h000, "R10");

      // R1 fill all data entries, R6 misses, then R2 hits
      for (int k = 0; k < 8; k++) run1(1, 20'h00100 + 20'(k), 12'h010 + 12'(k), "R6");
      for (int k = 0; k < 8; k++) run1(1, 20'h00100 + 20'(k), 12'hABC, "R1");
      for (int k = 0; k < 4; k++) run1(0, 20'h00200 + 20'(k), 12'h123, "R1");
      for (int k = 0; k < 4; k++) run1(0, 20'h00200 + 20'(k), 12'hFFF, "R2");

      // R4 saturation and R5 tie/victim on the instruction side
      for (int k = 0; k < 10; k++) run1(0, 20'h00203, 12'h004, "R3");
      run1(0, 20'h00201, 12'h008, "R3");
      run1(0, 20'h00204, 12'h00C, "R5");
      run1(0, 20'h00200, 12'h010, "R4");
      run1(0, 20'h00202, 12'h014, "R5");
      run1(0, 20'h00201, 12'h018, "R5");
      run1(0, 20'h00203, 12'h01C, "R4");

      // R7 simultaneous misses, simultaneous hits, lone instruction miss
      fork
         issue(1, 20'h00300, 12'h001, 0, "R7");
         issue(0, 20'h00400, 12'h002, 1, "R7");
      join
      settle();
      fork
         issue(1, 20'h00300, 12'h003, 0, "R2");
         issue(0, 20'h00400, 12'h004, 0, "R2");
      join
      settle();
      fork
         issue(1, 20'h00300, 12'h005, 0, "R7");
         issue(0, 20'h00401, 12'h006, 0, "R7");
      join
      settle();

      // R9 second-level write empties both caches
      @(negedge clk); l2_wr = 1; @(negedge clk); l2_wr = 0; mflush();
      run1(1, 20'h00300, 12'h020, "R9");
      run1(0, 20'h00400, 12'h024, "R9");

      // R8 second-level miss locks and flushes
      issue(1, 20'hF0001, 12'h000, 0, "R8");
      settle();
      for (int k = 0; k < 4; k++) begin
         chk(locked && !l2_req, "R8", "locked with no l2_req", {locked, l2_req}, 2'b10);
         chk(!i_ready && !d_ready, "R8", "ready while locked", {i_ready, d_ready}, 0);
         @(negedge clk);
      end
      os_reload_done = 1; @(negedge clk); os_reload_done = 0;
      chk(!locked, "R8", "locked after reload", locked, 0);
      run1(1, 20'h00300, 12'h030, "R8");
      run1(0, 20'h00400, 12'h034, "R8");

      // R3 mixed reference pattern on both sides
      for (int k = 0; k < 60; k++) begin
         lcg = (lcg * 1103515245 + 12345) & 32'h7FFFFFFF;
         a = 20'h00500 + 20'((lcg >> 8) % 12);
         run1((lcg >> 4) & 1, a, 12'(lcg), "R3");
      end
      repeat (4) @(negedge clk);
      chk(qi.size() == 0 && qd.size() == 0, "R6", "outstanding items", qi.size() + qd.size(), 0);
   endtask

   initial begin
      fork
         main();
         begin
            repeat (100000) @(posedge clk);
            n_checks++;
            n_fail++;
            $display("FAIL R6 watchdog: actual hung expected finished");
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule